// File: doc/BRIEF.md
# Selectable Coefficient Set Store

This block keeps a bank of filter coefficient sets and hands one complete set to a filter cell every clock. A host loads the bank through a narrow configuration port: an address, a data word and a write strobe. The strobe acts as a clock of its own, separate from the filter clock, and a word is stored on its rising edge. The configuration address space is shared with control registers that live elsewhere, and this block only accepts addresses whose top bit is zero.

On the filter side, a set number is registered on every rising filter-clock edge. On the next edge, all taps of that set are loaded side by side into an output register. The set number may differ on every cycle, so polyphase or adaptive filters can switch between coefficient sets without a gap.

With the default parameters there are 32 sets of 8 taps, and each tap is a 10-bit two's complement word.

Top module: `coef_set_bank`

## Requirements
- R1: While `rst_n` is low, `coef_out` is all zero and the registered set number is set 0, so the first edge after release loads set 0 whatever `set_sel` holds.
- R2: A rising edge of `cfg_wr` with `cfg_addr[8]` = 0 stores `cfg_data` as tap `cfg_addr[2:0]` of set `cfg_addr[7:3]`.
- R3: Lane t of the output, `coef_out[10t+9:10t]`, carries tap t of the selected set, bit-exact over the full two's complement range -512 (10'h200) to +511 (10'h1FF).
- R4: A `set_sel` value sampled at filter-clock edge N shows up on `coef_out` after edge N+1, and not after edge N.
- R5: `set_sel` may change on every clock, and after each edge the output holds the set sampled two edges earlier.
- R6: A write with `cfg_addr[8]` = 1 changes no stored coefficient.
- R7: A write whose strobe rises after the filter edge that loads the output does not alter that load: the old word stays for that cycle. If the strobe is back low before the next filter-clock falling edge, the new word appears after the next rising edge.
- R8: Stored coefficients are not cleared by `rst_n`, and after release the selected set reads back its earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Active-low asynchronous reset of the filter-side registers |
| cfg_wr | input | 1 | Write strobe; stores on its rising edge |
| cfg_addr | input | 9 | Write address: bit 8 selects control space, bits 7:3 the set, bits 2:0 the tap |
| cfg_data | input | 10 | Coefficient word to store |
| set_sel | input | 5 | Set number, registered on `clk` |
| coef_out | output | 80 | All taps of the selected set, tap t in bits 10t+9:10t |

## Verification
A new set number is due on `coef_out` two rising edges after the edge that samples it. The bench drives `set_sel` at falling edges and reads the output at later falling edges: one edge later it expects the old set and two edges later the new one, and when the select changes every cycle it compares against the set driven two falling edges earlier. A stored word is due on the output one rising edge after its strobe. The bench raises each strobe just after a rising edge and drops it before the falling edge, so the output is expected to be unchanged at the first falling edge and updated at the next one. Reset clearing is checked at the falling edge while reset is held. Selection of set 0 after reset is checked at the first falling edge after release.

// File: rtl/coef_set_bank.sv
module coef_set_bank #(
  parameter int SETS = 32,
  parameter int TAPS = 8,
  parameter int CW   = 10,
  parameter int AW   = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [CW-1:0]        cfg_data,
  input  logic [$clog2(SETS)-1:0] set_sel,
  output logic [TAPS*CW-1:0]   coef_out
);
  localparam int SB    = $clog2(SETS);
  localparam int TB    = $clog2(TAPS);
  localparam int IW    = SB + TB;
  localparam int DEPTH = SETS * TAPS;

  logic [CW-1:0] store [DEPTH];
  logic [SB-1:0] sel_q;
  logic [CW-1:0] lane_q [TAPS];

  wire          wr_hit = (cfg_addr[AW-1:IW] == '0);
  wire [IW-1:0] wr_idx = cfg_addr[IW-1:0];

  always_ff @(posedge cfg_wr)
    if (wr_hit) store[wr_idx] <= cfg_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_q <= '0;
    else        sel_q <= set_sel;

  for (genvar t = 0; t < TAPS; t++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lane_q[t] <= '0;
      else        lane_q[t] <= store[{sel_q, TB'(t)}];
    assign coef_out[t*CW +: CW] = lane_q[t];
  end
endmodule

module coef_set_bank_chk #(
  parameter int SETS = 32,
  parameter int TAPS = 8,
  parameter int CW   = 10,
  parameter int AW   = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_wr,
  input logic [AW-1:0]        cfg_addr,
  input logic [$clog2(SETS)-1:0] set_sel,
  input logic [TAPS*CW-1:0]   coef_out
);
  localparam int IW = $clog2(SETS) + $clog2(TAPS);

  logic [7:0] acc_cnt, ctl_cnt;
  logic [1:0] age;

  always_ff @(posedge cfg_wr or negedge rst_n)
    if (!rst_n) begin
      acc_cnt <= '0;
      ctl_cnt <= '0;
    end else if (cfg_addr[AW-1:IW] == '0) acc_cnt <= acc_cnt + 8'd1;
    else                                  ctl_cnt <= ctl_cnt + 8'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  always @(posedge clk)
    if (!rst_n) a_r1_reset_clear: assert (coef_out == '0) else $error("R1 output not clear in reset");

  a_r1_first_edge_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> coef_out == '0);

  a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(set_sel, 2) == $past(set_sel, 3) &&
     $past(acc_cnt) == $past(acc_cnt, 2)) |-> $stable(coef_out));

  a_r6_ctrl_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(ctl_cnt) != $past(ctl_cnt, 2) &&
     $past(set_sel, 2) == $past(set_sel, 3) &&
     $past(acc_cnt) == $past(acc_cnt, 2)) |-> $stable(coef_out));
endmodule

bind coef_set_bank coef_set_bank_chk #(.SETS(SETS), .TAPS(TAPS), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .set_sel(set_sel), .coef_out(coef_out)
);

// File: tb/sim_coef_set_bank.sv
`timescale 1ns/1ps
module sim_coef_set_bank;
  localparam int OW = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [8:0]    cfg_addr = '0;
  logic [9:0]    cfg_data = '0;
  logic [4:0]    set_sel = '0;
  logic [OW-1:0] coef_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [9:0] model [256];

  coef_set_bank u0 (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
                    .cfg_data(cfg_data), .set_sel(set_sel), .coef_out(coef_out));

  always #10 clk = ~clk;

  // {set[4:0], tap[2:0], value[9:0]}
  localparam logic [17:0] VEC [12] = '{
    {5'd0,  3'd0, 10'h001}, {5'd0,  3'd7, 10'h3FF}, {5'd1,  3'd3, 10'h155},
    {5'd2,  3'd5, 10'h2AA}, {5'd7,  3'd1, 10'h0F0}, {5'd12, 3'd6, 10'h30F},
    {5'd16, 3'd2, 10'h200}, {5'd19, 3'd4, 10'h1FF}, {5'd23, 3'd0, 10'h07E},
    {5'd27, 3'd7, 10'h381}, {5'd30, 3'd5, 10'h123}, {5'd31, 3'd3, 10'h2DB}
  };

  function automatic logic [OW-1:0] exp_set(input int s);
    logic [OW-1:0] r;
    for (int t = 0; t < 8; t++) r[t*10 +: 10] = model[s*8 + t];
    return r;
  endfunction

  task automatic chk(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_pulse(input logic [8:0] a, input logic [9:0] d);
    cfg_addr = a;
    cfg_data = d;
    #1 cfg_wr = 1'b1;
    #5 cfg_wr = 1'b0;
  endtask

  task automatic store(input int s, input int t, input logic [9:0] d);
    @(posedge clk);
    #1 wr_pulse({1'b0, 5'(s), 3'(t)}, d);
    model[s*8 + t] = d;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int seq [12];
    set_sel = 5'd9;
    repeat (3) @(negedge clk);
    chk("R1 output zero in reset", coef_out, '0);

    // Fill the whole bank while reset is held; storage is not on rst_n
    for (int s = 0; s < 32; s++)
      for (int t = 0; t < 8; t++)
        store(s, t, 10'((s * 37 + t * 11 + 5) % 1024));

    @(negedge clk);
    chk("R1 output still zero", coef_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first load is set 0", coef_out, exp_set(0));
    @(negedge clk);
    chk("R2 fill readback set 9", coef_out, exp_set(9));

    // Vector table: write one tap, select its set, check the lane and the set
    for (int i = 0; i < 12; i++) begin
      int s, t;
      s = int'(VEC[i][17:13]);
      t = int'(VEC[i][12:10]);
      store(s, t, VEC[i][9:0]);
      @(negedge clk);
      set_sel = 5'(s);
      @(negedge clk);
      @(negedge clk);
      chk("R2 stored tap", OW'(coef_out[t*10 +: 10]), OW'(VEC[i][9:0]));
      chk("R3 lane layout", coef_out, exp_set(s));
    end

    // R3 extremes in lanes 0 and 7
    store(31, 0, 10'h200);
    store(31, 7, 10'h1FF);
    @(negedge clk);
    set_sel = 5'd31;
    @(negedge clk);
    @(negedge clk);
    chk("R3 lane0 -512", OW'($signed(coef_out[9:0]) == -10'sd512), OW'(1));
    chk("R3 lane7 +511", OW'($signed(coef_out[79:70]) == 10'sd511), OW'(1));

    // R4 latency: two edges from sample to output
    @(negedge clk);
    set_sel = 5'd4;
    @(negedge clk);
    chk("R4 not after first edge", coef_out, exp_set(31));
    @(negedge clk);
    chk("R4 after second edge", coef_out, exp_set(4));

    // R5 select changing every clock
    for (int i = 0; i < 12; i++) seq[i] = (i * 7 + 3) % 32;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i >= 2) chk("R5 per-clock select", coef_out, exp_set(seq[i-2]));
      set_sel = 5'(seq[i]);
    end
    @(negedge clk);
    @(negedge clk);
    chk("R5 final select", coef_out, exp_set(seq[11]));

    // R6 control-space writes leave storage alone
    set_sel = 5'd13;
    @(negedge clk);
    @(negedge clk);
    for (int t = 0; t < 8; t++) begin
      @(posedge clk);
      #1 wr_pulse({1'b1, 5'd13, 3'(t)}, ~model[13*8 + t]);
    end
    @(negedge clk);
    chk("R6 output unchanged", coef_out, exp_set(13));
    set_sel = 5'd14;
    @(negedge clk);
    set_sel = 5'd13;
    @(negedge clk);
    @(negedge clk);
    chk("R6 reselect unchanged", coef_out, exp_set(13));

    // R7 write just after the loading edge
    @(posedge clk);
    #1 wr_pulse({1'b0, 5'd13, 3'd3}, 10'h2C5);
    @(negedge clk);
    chk("R7 old value this cycle", coef_out, exp_set(13));
    model[13*8 + 3] = 10'h2C5;
    @(negedge clk);
    chk("R7 new value next cycle", coef_out, exp_set(13));

    // R8 mid-run reset keeps storage
    set_sel = 5'd12;
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 async clear", coef_out, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 set 0 retained", coef_out, exp_set(0));
    @(negedge clk);
    chk("R8 set 12 retained", coef_out, exp_set(12));

    done = 1'b1;
    summary();
  end
endmodule